// File: doc/BRIEF.md
# Serial Command Receiver with Chained Output

This block is a write-only serial slave that sits in front of a display controller's register file. A host drives three wires: an active-low select, a serial clock and a data line. While select is low, the block shifts in bits on each rising serial clock edge, most significant bit first. When select returns high, the block takes the 16 most recent bits as one command word. The upper byte is a register address and the lower byte is the value to write. The block then issues a single-cycle write strobe, with address and data, in its own system clock domain.

A serial output forwards the bit leaving the top of the shift register, changing on falling serial clock edges. Several receivers can therefore share select and clock, with each one's output feeding the next one's data input. In a burst of 16×N bits, the last receiver in the chain gets the first word and the first receiver keeps the last word.

All three serial inputs are resynchronised into the system clock, which must run at least four times faster than the serial clock. When receivers are chained, each serial clock half period must also exceed the output delay of roughly four system cycles. The serial clock may rest high or low between transfers.

Top module: `serial_cmd_rx`

## Requirements
- R1: A committed word carries bit 15 as the first bit received. Bits 15..8 appear on `wr_addr_o` and bits 7..0 on `wr_data_o`.
- R2: Serial clock edges that occur while `cs_n_i` is high shift nothing and produce no strobe.
- R3: On the rising edge of `cs_n_i`, the last 16 bits sampled are committed, and any earlier bits of a longer burst are discarded.
- R4: `wr_stb_o` is high for exactly one system cycle per commit. It fires only when at least 16 rising serial clock edges were seen with select low, and shorter transfers produce no strobe.
- R5: The bit counter never exceeds 16; it saturates there.
- R6: On each falling serial clock edge with select low, `sdo_o` takes the bit received 16 rising edges earlier, or 0 if fewer were received. In a two-receiver chain, the downstream receiver commits the first 16 bits of a 32-bit burst.
- R7: `sdo_o` is 0 whenever select has been high for a system cycle.
- R8: Transfers work with the serial clock idling low and with it idling high.
- R9: A falling edge of select clears the shift register and the bit counter. Bits from an earlier transfer therefore neither reach `sdo_o` nor count toward 16.
- R10: `wr_addr_o` and `wr_data_o` change only in the cycle `wr_stb_o` is high, and otherwise hold the last committed word.
- R11: After reset, `wr_stb_o`, `wr_addr_o`, `wr_data_o` and `sdo_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Chained serial data out |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Committed address byte |
| wr_data_o | output | 8 | Committed data byte |

## Verification
The assertions take several things for granted about the inputs:
- The system clock oversamples the serial clock enough that each serial clock level persists for at least two system cycles.
- Select does not change in the same synchronised cycle as a serial clock edge.
- Data is stable around each rising serial clock edge.

The stimulus meets these conditions as follows:
- The serial clock half period is eight system cycles.
- Data changes only while the serial clock is low.
- Select moves half a serial period away from any clock edge.
- All input changes fall midway between system clock edges.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned ADDR_BITS = 8;
  // sync vector bit order: {sdi, sclk, cs_n}
  localparam int unsigned SYNC_W    = 3;
  localparam logic [SYNC_W-1:0] SYNC_IDLE = 3'b001;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/scr_edge.sv
module scr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic sclk_s_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_idle_o
);
  logic cs_n_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_s_i;
      sclk_q <= sclk_s_i;
    end
  end

  assign cs_fall_o   = cs_n_q & ~cs_n_s_i;
  assign cs_rise_o   = ~cs_n_q & cs_n_s_i;
  assign cs_idle_o   = cs_n_s_i;
  // serial clock edges only count with select active
  assign sclk_rise_o = ~sclk_q & sclk_s_i & ~cs_n_s_i;
  assign sclk_fall_o = sclk_q & ~sclk_s_i & ~cs_n_s_i;
endmodule

// File: rtl/scr_shift.sv
module scr_shift #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              drain_i,
  input  logic              idle_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[WORD_W-2:0], sdi_i};
      if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sdo_q <= 1'b0;
    else if (idle_i)  sdo_q <= 1'b0;
    else if (drain_i) sdo_q <= sr_q[WORD_W-1];
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_W'(WORD_W));
  assign sdo_o  = sdo_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && (sr_q == '0));
  p_sdo_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !sdo_q);
  p_sdo_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_q) |-> $past(drain_i || idle_i));
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned ADDR_W = ADDR_BITS,
  localparam int unsigned DATA_W = WORD_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [SYNC_W-1:0] sync_s;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall, cs_idle, full;
  logic [WORD_W-1:0] word;
  logic              stb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  scr_sync #(.W(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sclk_i, cs_n_i}),
    .q_o   (sync_s)
  );

  scr_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_s_i   (sync_s[0]),
    .sclk_s_i   (sync_s[1]),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .cs_idle_o  (cs_idle)
  );

  scr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_fall),
    .shift_i(sclk_rise),
    .drain_i(sclk_fall),
    .idle_i (cs_idle),
    .sdi_i  (sync_s[2]),
    .word_o (word),
    .full_o (full),
    .sdo_o  (sdo_o)
  );

  // commit only on select release after a complete word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      stb_q <= cs_rise & full;
      if (cs_rise && full) begin
        addr_q <= word[WORD_W-1:DATA_W];
        data_q <= word[DATA_W-1:0];
      end
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  p_stb_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
  p_stb_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(full));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(wr_addr_o) && $stable(wr_data_o)) |-> wr_stb_o);
endmodule

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
  localparam int HALF = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo_a, sdo_b, stb_a, stb_b;
  logic [7:0] addr_a, data_a, addr_b, data_b;

  always #5 clk = ~clk;

  serial_cmd_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_a), .wr_stb_o(stb_a), .wr_addr_o(addr_a), .wr_data_o(data_a)
  );
  serial_cmd_rx dut_chain_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdo_a),
    .sdo_o(sdo_b), .wr_stb_o(stb_b), .wr_addr_o(addr_b), .wr_data_o(data_b)
  );

  int chk_cnt = 0;
  int err_cnt = 0;
  bit done = 0;
  logic [15:0] q_a[$], q_b[$];
  string       t_a[$], t_b[$];
  logic [15:0] last_a = '0, last_b = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected words as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stb_a) begin
        if (q_a.size() == 0) check(1'b0, "R4", "unexpected strobe first rx", {addr_a, data_a}, 0);
        else begin
          automatic logic [15:0] e = q_a.pop_front();
          automatic string tg = t_a.pop_front();
          check({addr_a, data_a} == e, tg, "first rx word", {addr_a, data_a}, e);
        end
      end
      if (stb_b) begin
        if (q_b.size() == 0) check(1'b0, "R4", "unexpected strobe chained rx", {addr_b, data_b}, 0);
        else begin
          automatic logic [15:0] e = q_b.pop_front();
          automatic string tg = t_b.pop_front();
          check({addr_b, data_b} == e, tg, "chained rx word", {addr_b, data_b}, e);
        end
      end
    end
  end

  // driver: model both receivers from the requirements, then drive the wires
  task automatic send(input logic [63:0] bits, input int n, input bit idle_hi,
                      input string tag_a, input string tag_b);
    logic [15:0] up = '0, dn = '0;
    for (int k = n - 1; k >= 0; k--) begin
      dn = {dn[14:0], up[15]};
      up = {up[14:0], bits[k]};
    end
    if (n >= 16) begin
      q_a.push_back(up); t_a.push_back(tag_a); last_a = up;
      q_b.push_back(dn); t_b.push_back(tag_b); last_b = dn;
    end
    sclk = idle_hi;
    #(2*HALF);
    cs_n = 1'b0;
    #HALF;
    for (int k = n - 1; k >= 0; k--) begin
      sclk = 1'b0;
      sdi = bits[k];
      #HALF;
      sclk = 1'b1;
      #HALF;
    end
    if (!idle_hi) begin
      sclk = 1'b0;
      #HALF;
    end
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt + 1);
      $finish;
    end
  end

  initial begin
    #42;
    check(stb_a == 0 && sdo_a == 0 && addr_a == 0 && data_a == 0, "R11", "reset state",
          {stb_a, sdo_a, addr_a, data_a}, 0);
    #18 rst_n = 1'b1;
    #100;

    send(64'hA53C, 16, 1'b0, "R1", "R6");
    send(64'h0F81, 16, 1'b1, "R8", "R6");
    send(64'h12_7E_C3, 24, 1'b0, "R3", "R6");
    send(64'hBEEF_5A69, 32, 1'b1, "R3", "R6");
    // chain word must be zero: previous leftovers cleared on select fall
    send(64'h3C3C, 16, 1'b0, "R1", "R9");

    // short burst: no strobe, outputs hold
    send(64'h2AB, 10, 1'b1, "R4", "R4");
    check({addr_a, data_a} == last_a, "R10", "hold after short burst", {addr_a, data_a}, last_a);
    check({addr_b, data_b} == last_b, "R10", "chain hold after short burst", {addr_b, data_b}, last_b);

    // two short bursts must not add up to a word
    send(64'h3FF, 10, 1'b0, "R9", "R9");
    send(64'hFF, 8, 1'b0, "R9", "R9");
    check({addr_a, data_a} == last_a, "R9", "no commit from split bursts", {addr_a, data_a}, last_a);

    // clock activity with select high
    sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b1; #HALF;
      sclk = 1'b0; #HALF;
      check(sdo_a == 1'b0, "R7", "sdo while deselected", sdo_a, 0);
    end
    cs_n = 1'b0; #(2*HALF); cs_n = 1'b1; #(4*HALF);
    check({addr_a, data_a} == last_a, "R2", "no commit from deselected clocks", {addr_a, data_a}, last_a);

    send(64'h6D_0000, 24, 1'b1, "R3", "R6");
    send(64'h8001, 16, 1'b1, "R8", "R6");

    check(q_a.size() == 0, "R4", "first rx missing strobes", q_a.size(), 0);
    check(q_b.size() == 0, "R4", "chained rx missing strobes", q_b.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
    $finish;
  end
endmodule